// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing controller of a serial EEPROM on a two-wire bus. A fast system clock samples the clock and data lines through synchronisers. The block finds the bus framing conditions, shifts in bytes, and pulls the data line low through an active-low drive enable when it acknowledges or sends a zero. A transaction opens with a select byte. That byte carries a fixed device code, the upper memory address bits and the read/write flag. A write goes on with a byte address and data bytes. A read returns bytes from the current address. A random read is a write of the address alone, then a repeated START with a read select.

The page buffer, the program timer and the array are outside the block. Each accepted data byte is handed out as a one-cycle write request with its address. A one-cycle read request asks for a byte, which must be valid on the cycle after the request and held until the next request. A one-cycle program-start pulse tells the timer to commit the page. While the timer reports busy, the controller does not respond on the bus. A write-lock input blocks all data writes and still lets the select and address bytes through. It is low when not driven.

Top module: `seeprom_slave`

## Requirements
- R1: After reset the data drive is released and no write, read or program-start pulse is issued until a bus transaction arrives.
- R2: START is the data line falling while the clock line is high, and STOP is the data line rising while the clock line is high. Data is taken on the rising clock edge, most significant bit first.
- R3: A select byte whose bits 7..4 are 1010 is acknowledged by holding the data line low through the 9th clock. Bits 3..1 give memory address bits 10..8, and bit 0 is 1 for read and 0 for write.
- R4: A select byte that does not match gets no acknowledge, and the controller stays silent, with later bytes also unacknowledged, until the next START.
- R5: After a write select, the address byte is acknowledged, and the current address becomes {select bits 3..1, address byte}.
- R6: Each accepted write data byte is acknowledged and produces exactly one write request carrying the current address and the byte. Only the low 4 address bits then step, wrapping inside the 16-byte page.
- R7: A STOP that arrives as the first clock after a data byte's acknowledge, when at least one data byte was accepted, produces exactly one program-start pulse.
- R8: With write-lock high, the select and address bytes are still acknowledged, but every data byte gets NoACK, produces no write request and leaves memory unchanged, and no program-start pulse follows.
- R9: A STOP at any other point (mid-byte, or with no data accepted) produces no program-start pulse.
- R10: While the program timer reports busy, the controller ignores START and all bytes, gives no acknowledge and keeps the drive released. It responds normally again once busy drops.
- R11: A read sends the byte at the current address MSB first. A master ACK steps the full address by one, wrapping from the top of the array to 0, and sends the next byte. A master NoACK releases the bus until STOP or START.
- R12: A repeated START in any state, including partway through a data byte, restarts select-byte reception.
- R13: The data drive changes only while the synchronised clock line is low, except when it is forced off by busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (resolved wired-AND) |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_lock | input | 1 | 1 blocks all data writes; tie low when unused |
| prog_busy | input | 1 | Program timer is running |
| mem_addr | output | ADDR_W | Current memory address |
| mem_wr_en | output | 1 | One-cycle write request for mem_addr |
| mem_wr_data | output | 8 | Byte to write |
| mem_rd_req | output | 1 | One-cycle read request for mem_addr |
| mem_rd_data | input | 8 | Read byte, valid the cycle after mem_rd_req |
| prog_start | output | 1 | One-cycle pulse that starts the program cycle |

## Verification
On every cycle the assertions check the following: the drive changes only with the clock line low, busy silences the drive, no write request follows a cycle with write-lock high, write requests last one cycle, and a page step keeps the upper address bits. Only the bench scenarios can show the byte-level results: acknowledge or NoACK on each byte, stored and returned data, page and array wrap, the program-start slot after STOP, and recovery after a mismatch, a busy period or a repeated START.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_ADR,
      ST_WR,
      ST_RD,
      ST_RDNAK
   } slv_state_e;

   localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/seeprom_bus_sampler.sv
module seeprom_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic                   scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
         scl_d  <= scl_sh[SYNC_STAGES-1];
         sda_d  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_lvl   = scl_sh[SYNC_STAGES-1];
   assign sda_lvl   = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   // framing conditions: data edge while clock held high on both samples
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/seeprom_sel_decode.sv
module seeprom_sel_decode #(
   parameter int ADDR_W = 11
) (
   input  logic [7:0]        sel_byte,
   output logic              hit,
   output logic              is_read,
   output logic [ADDR_W-9:0] hi_addr
);
   import seeprom_pkg::*;

   logic spare_ok;

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_width
         $error("ADDR_W must be 9, 10 or 11");
      end
      if (ADDR_W == 11) begin : g_all_addr
         assign spare_ok = 1'b1;
      end else begin : g_spare_zero
         // select bits above the array size must be zero to match
         assign spare_ok = (sel_byte[3:ADDR_W-7] == '0);
      end
   endgenerate

   assign hit     = (sel_byte[7:4] == DEV_CODE) && spare_ok;
   assign is_read = sel_byte[0];
   assign hi_addr = sel_byte[ADDR_W-8:1];
endmodule

// File: rtl/seeprom_addr_ctr.sv
module seeprom_addr_ctr #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_hi,
   input  logic [ADDR_W-9:0] hi_val,
   input  logic              set_lo,
   input  logic [7:0]        lo_val,
   input  logic              step_page,
   input  logic              step_all,
   output logic [ADDR_W-1:0] addr
);
   generate
      if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page
         $error("PAGE_W must be between 1 and 8");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (set_hi) begin
         addr[ADDR_W-1:8] <= hi_val;
      end else if (set_lo) begin
         addr[7:0] <= lo_val;
      end else if (step_page) begin
         addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
      end else if (step_all) begin
         addr <= addr + 1'b1;
      end
   end

   // R6: a page step never disturbs the row bits
   assert_page_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step_page && !set_hi && !set_lo |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave #(
   parameter int ADDR_W      = 11,
   parameter int PAGE_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_drive_low,
   input  logic              wr_lock,
   input  logic              prog_busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_wr_en,
   output logic [7:0]        mem_wr_data,
   output logic              mem_rd_req,
   input  logic [7:0]        mem_rd_data,
   output logic              prog_start
);
   import seeprom_pkg::*;

   localparam int HI_W = ADDR_W - 8;

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic sel_hit, sel_rd;
   logic [HI_W-1:0] sel_hi;

   slv_state_e state, nxt;
   logic [3:0] bit_cnt;
   logic       in_ack, wr_took, wrote_any, mack, rd_p1;
   logic [7:0] shreg, tx;
   logic       rx_state, byte_done, set_hi, set_lo, step_page, step_all, prog_slot;

   seeprom_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   seeprom_sel_decode #(.ADDR_W(ADDR_W)) u_sel (
      .sel_byte(shreg), .hit(sel_hit), .is_read(sel_rd), .hi_addr(sel_hi));

   assign rx_state  = (state == ST_SEL) || (state == ST_ADR) || (state == ST_WR);
   assign byte_done = scl_fall && !in_ack && rx_state && (bit_cnt == 4'd8);
   assign set_hi    = !prog_busy && byte_done && (state == ST_SEL) && sel_hit;
   assign set_lo    = !prog_busy && byte_done && (state == ST_ADR);
   assign step_page = !prog_busy && scl_fall && in_ack && (state == ST_WR) && wr_took;
   assign step_all  = !prog_busy && scl_fall && in_ack && (state == ST_RD) && mack;
   // the STOP clock is the first rise after the acknowledge: one bit shifted
   assign prog_slot = (state == ST_WR) && !in_ack && (bit_cnt == 4'd1) && wrote_any;

   seeprom_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .set_hi(set_hi), .hi_val(sel_hi),
      .set_lo(set_lo), .lo_val(shreg), .step_page(step_page), .step_all(step_all),
      .addr(mem_addr));

   assign mem_wr_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;  nxt <= ST_IDLE;
         bit_cnt <= '0;     in_ack <= 1'b0;   wr_took <= 1'b0;  wrote_any <= 1'b0;
         mack <= 1'b0;      rd_p1 <= 1'b0;    shreg <= '0;      tx <= '0;
         sda_drive_low <= 1'b0;
         mem_wr_en <= 1'b0; mem_rd_req <= 1'b0; prog_start <= 1'b0;
      end else begin
         mem_wr_en  <= 1'b0;
         mem_rd_req <= 1'b0;
         prog_start <= 1'b0;
         rd_p1      <= mem_rd_req;
         if (prog_busy) begin
            state <= ST_IDLE; sda_drive_low <= 1'b0; in_ack <= 1'b0;
            bit_cnt <= '0;    wrote_any <= 1'b0;     rd_p1 <= 1'b0;
         end else if (start_det) begin
            state <= ST_SEL;  sda_drive_low <= 1'b0; in_ack <= 1'b0;
            bit_cnt <= '0;    wrote_any <= 1'b0;     rd_p1 <= 1'b0;
         end else if (stop_det && state != ST_RD) begin
            prog_start <= prog_slot;
            state <= ST_IDLE; sda_drive_low <= 1'b0; in_ack <= 1'b0;
            bit_cnt <= '0;    wrote_any <= 1'b0;
         end else begin
            if (rd_p1 && state == ST_RD) begin
               tx            <= mem_rd_data;
               sda_drive_low <= ~mem_rd_data[7];
            end
            if (scl_rise) begin
               if (rx_state && !in_ack && bit_cnt != 4'd8) begin
                  shreg   <= {shreg[6:0], sda_lvl};
                  bit_cnt <= bit_cnt + 4'd1;
               end
               if (state == ST_RD && in_ack) mack <= ~sda_lvl;
            end
            if (scl_fall) begin
               if (in_ack) begin
                  sda_drive_low <= 1'b0;
                  in_ack        <= 1'b0;
                  bit_cnt       <= '0;
                  state         <= nxt;
                  if (state == ST_RD) begin
                     if (mack) mem_rd_req <= 1'b1;
                     else      state      <= ST_RDNAK;
                  end else if (nxt == ST_RD) begin
                     mem_rd_req <= 1'b1;
                  end
               end else if (byte_done) begin
                  in_ack <= 1'b1;
                  unique case (state)
                     ST_SEL: begin
                        if (sel_hit) begin
                           sda_drive_low <= 1'b1;
                           nxt <= sel_rd ? ST_RD : ST_ADR;
                        end else begin
                           in_ack <= 1'b0;
                           state  <= ST_IDLE;
                        end
                     end
                     ST_ADR: begin
                        sda_drive_low <= 1'b1;
                        nxt <= ST_WR;
                     end
                     default: begin
                        nxt     <= ST_WR;
                        wr_took <= !wr_lock;
                        if (!wr_lock) begin
                           sda_drive_low <= 1'b1;
                           mem_wr_en     <= 1'b1;
                           wrote_any     <= 1'b1;
                        end
                     end
                  endcase
               end else if (state == ST_RD) begin
                  if (bit_cnt == 4'd7) begin
                     sda_drive_low <= 1'b0;
                     in_ack        <= 1'b1;
                     nxt           <= ST_RD;
                  end else begin
                     tx            <= {tx[6:0], 1'b0};
                     sda_drive_low <= ~tx[6];
                     bit_cnt       <= bit_cnt + 4'd1;
                  end
               end
            end
         end
      end
   end

   // R13: drive edges happen only in the low half of the bus clock
   assert_drive_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) && !$past(prog_busy) |-> !$past(scl_lvl));
   // R10: busy silences the bus drive
   assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> !sda_drive_low);
   // R8: no write request follows a locked cycle
   assert_lock_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> !$past(wr_lock));
   // R6: write requests are single-cycle pulses
   assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en);
   // R7: program start is a single-cycle pulse
   assert_prog_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);
endmodule

// File: tb/seeprom_slave_tb.sv
module seeprom_slave_tb;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic wr_lock = 1'b0, prog_busy = 1'b0;
   logic sda_drive_low, mem_wr_en, mem_rd_req, prog_start;
   logic [10:0] mem_addr;
   logic [7:0]  mem_wr_data, rd_data;
   logic        sda_bus;

   logic [7:0] mem_model [0:2047];
   logic [7:0] exp_mem   [0:2047];
   int n_chk = 0, n_bad = 0, prog_cnt = 0, r13_viol = 0;
   logic prev_drv = 1'b0;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_drive_low;

   seeprom_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
      .sda_drive_low(sda_drive_low), .wr_lock(wr_lock), .prog_busy(prog_busy),
      .mem_addr(mem_addr), .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data),
      .mem_rd_req(mem_rd_req), .mem_rd_data(rd_data), .prog_start(prog_start));

   // external array model
   always @(posedge clk) begin
      if (mem_wr_en)  mem_model[mem_addr] <= mem_wr_data;
      if (mem_rd_req) rd_data <= mem_model[mem_addr];
   end

   always @(negedge clk) begin
      if (prog_start) prog_cnt++;
      if (rst_n && sda_drive_low !== prev_drv && scl_m && !prog_busy) r13_viol++;
      prev_drv = sda_drive_low;
   end

   function automatic logic [7:0] init_val(input logic [10:0] a);
      return a[7:0] ^ {a[10:8], 5'h0b};
   endfunction

   function automatic logic [10:0] page_next(input logic [10:0] a);
      return {a[10:4], 4'(a[3:0] + 4'd1)};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(H);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1; tick(H);
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 7; i > 7 - nb; i--) begin
         sda_m = b[i]; tick(H);
         scl_m = 1'b1; tick(H);
         scl_m = 1'b0;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H/2);
      acked = !sda_bus;
      tick(H/2);
      scl_m = 1'b0;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tick(H);
         scl_m = 1'b1; tick(H/2);
         b = {b[6:0], sda_bus};
         tick(H/2);
         scl_m = 1'b0;
      end
      sda_m = ~give_ack; tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(1);
      sda_m = 1'b1;
   endtask

   task automatic wr_seq(input logic [10:0] a, input int n, input logic [7:0] d0,
                         input bit lock, input string tag);
      bit ak;
      int pc;
      logic [10:0] p;
      logic [7:0] d;
      pc = prog_cnt; wr_lock = lock; p = a;
      bus_start();
      send_byte({4'b1010, a[10:8], 1'b0}, ak);
      chk({tag, " R2 R3 write select ack"}, ak, 1);
      send_byte(a[7:0], ak);
      chk({tag, " R5 address ack"}, ak, 1);
      for (int i = 0; i < n; i++) begin
         d = d0 + 8'(i * 37);
         send_byte(d, ak);
         chk(lock ? {tag, " R8 locked data NoACK"} : {tag, " R6 data ack"}, ak, lock ? 0 : 1);
         if (!lock) exp_mem[p] = d;
         p = page_next(p);
      end
      bus_stop(); tick(4);
      chk(lock ? {tag, " R8 no program start"} : {tag, " R7 program start"},
          prog_cnt - pc, (lock || n == 0) ? 0 : 1);
      wr_lock = 1'b0;
   endtask

   task automatic rd_seq(input logic [10:0] a, input int n, input string tag);
      bit ak;
      logic [10:0] p;
      logic [7:0] b;
      p = a;
      bus_start();
      send_byte({4'b1010, a[10:8], 1'b0}, ak);
      chk({tag, " R3 dummy select ack"}, ak, 1);
      send_byte(a[7:0], ak);
      chk({tag, " R5 dummy address ack"}, ak, 1);
      bus_start();
      send_byte({4'b1010, a[10:8], 1'b1}, ak);
      chk({tag, " R12 read select after repeated START"}, ak, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, b);
         chk({tag, " R2 R11 read data"}, b, exp_mem[p]);
         p = p + 11'd1;
      end
      bus_stop();
   endtask

   initial begin : main
      bit ak;
      int pc;
      logic [7:0] b;
      for (int i = 0; i < 2048; i++) begin
         mem_model[i] = init_val(11'(i));
         exp_mem[i]   = init_val(11'(i));
      end
      void'($urandom(32'd7));
      tick(5);
      // R1: reset state
      chk("R1 drive released in reset", sda_drive_low, 0);
      rst_n = 1'b1; tick(6);
      chk("R1 drive released after reset", sda_drive_low, 0);
      chk("R1 no write pulse", mem_wr_en, 0);
      chk("R1 no read pulse", mem_rd_req, 0);
      chk("R1 no program start", prog_cnt, 0);

      // byte write then random read
      wr_seq(11'h2A5, 1, 8'h3C, 1'b0, "byte");
      rd_seq(11'h2A5, 1, "byte");

      // R4: mismatched select, then a matching pattern without START
      bus_start();
      send_byte(8'hB0, ak); chk("R4 mismatch NoACK", ak, 0);
      send_byte(8'hA0, ak); chk("R4 silent until START", ak, 0);
      bus_stop();

      // R6: page roll-over
      wr_seq(11'h13E, 4, 8'h51, 1'b0, "page");
      rd_seq(11'h130, 2, "page low");
      rd_seq(11'h13E, 2, "page high");
      chk("R6 row untouched", exp_mem[11'h140], init_val(11'h140));

      // R8: write lock
      wr_seq(11'h455, 2, 8'h99, 1'b1, "lock");
      rd_seq(11'h455, 2, "lock readback");

      // R9: STOP right after address, and STOP mid-byte
      pc = prog_cnt;
      bus_start();
      send_byte(8'hA0, ak); send_byte(8'h10, ak);
      bus_stop(); tick(4);
      chk("R9 STOP with no data", prog_cnt - pc, 0);
      bus_start();
      send_byte(8'hA0, ak); send_byte(8'h20, ak);
      send_byte(8'h6E, ak); chk("R6 data ack before partial", ak, 1);
      exp_mem[11'h020] = 8'h6E;
      send_bits(8'hFF, 3);
      bus_stop(); tick(4);
      chk("R9 STOP mid-byte", prog_cnt - pc, 0);
      rd_seq(11'h020, 1, "partial");

      // R12: repeated START partway through a data byte
      bus_start();
      send_byte(8'hA2, ak); send_byte(8'h77, ak);
      send_bits(8'h00, 5);
      bus_start();
      send_byte(8'hA3, ak); chk("R12 restart mid data byte", ak, 1);
      recv_byte(1'b0, b); chk("R12 R11 read after restart", b, exp_mem[11'h177]);
      bus_stop();

      // R10: busy program cycle
      wr_seq(11'h601, 1, 8'hC4, 1'b0, "busy prep");
      prog_busy = 1'b1;
      pc = prog_cnt;
      bus_start();
      send_byte(8'hAC, ak); chk("R10 no ack while busy", ak, 0);
      send_byte(8'h01, ak); chk("R10 address ignored while busy", ak, 0);
      bus_stop();
      chk("R10 no program start while busy", prog_cnt - pc, 0);
      prog_busy = 1'b0; tick(4);
      rd_seq(11'h601, 1, "R10 after busy");

      // R11: sequential read across the top of the array
      rd_seq(11'h7FE, 4, "wrap");

      // constrained random write/read pairs
      for (int it = 0; it < 24; it++) begin
         logic [10:0] a;
         int n;
         a = 11'($urandom);
         n = 1 + int'($urandom % 4);
         wr_seq(a, n, 8'($urandom), ($urandom % 6) == 0, "rand");
         rd_seq(a, n, "rand");
      end

      chk("R13 drive moved while SCL high", r13_viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(negedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule